// File: doc/BRIEF.md
# Programmable Up-Counting Tick Timer

This block is a single timer channel behind a small word-wide register bus. A 28-bit counter steps up by one on each prescaled tick. The prescaler divides the input clock by a divisor taken from the control register. A programmable end marker sets the count at which the counter falls back to zero. Without a marker, the counter falls back to zero only when it passes its all-ones value. Each return to zero is a wrap. A wrap raises an interrupt-pending flag, and an enable bit gates that flag onto the interrupt line.

Two modes are available. In the periodic mode the channel keeps counting after each wrap, so it serves as a free-running time base or a periodic tick source. In the one-shot mode the channel halts on its first wrap and clears its own run bit, so software can arm one delay at a time.

The bus has no handshake and no back-pressure: a write with `bus_we` high is taken at the next rising clock edge. `bus_rdata` is a combinational view of the register selected by `bus_addr`. Address bits [1:0] are not decoded.

Top module: `tick_timer`

## Requirements
- R1: After reset the end marker, count, control and interrupt registers all read 0, the interrupt output is low and the count does not advance.
- R2: Registers are selected by byte address: 0x0 end marker (bits [27:0]), 0x4 count (bits [27:0], read/write), 0x8 control (bit 28 run, bit 24 periodic, bits [15:0] divisor), 0xC interrupt (bit 20 enable, bit 16 pending). Every other bit reads 0, and writing 1 to the pending bit never sets it.
- R3: While the run bit is 1, the count rises by exactly one every D clock cycles, where D is the divisor; a divisor of 0 or 1 gives one step per clock. With the run bit at 0 the count holds.
- R4: With a nonzero end marker M, the step that would bring the count to M brings it to 0 instead, so a periodic channel cycles through 0..M-1.
- R5: With an end marker of 0, the count wraps to 0 only on the step after 0x0FFFFFFF, and that wrap also raises the pending flag.
- R6: In periodic mode (bit 24 = 1) counting continues after a wrap and the run bit stays 1.
- R7: In one-shot mode (bit 24 = 0) a wrap leaves the count at 0, clears the run bit (control reads back with bit 28 low) and stops counting.
- R8: Every wrap sets the pending flag. The interrupt output is high exactly when both pending and interrupt enable are 1.
- R9: Writing 1 to bit 16 of the interrupt register clears pending, and writing 0 there leaves it unchanged. A wrap in the same cycle as a clearing write leaves pending set.
- R10: Writing the count register loads the counter with the written value and restarts the prescaler phase, so the next step comes a full D cycles after the write.
- R11: Writing 0 to the control register stops the counter at its current value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte address of the register; bits [3:2] select it |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, taken at the next rising edge |
| bus_rdata | output | 32 | Combinational read data of the addressed register |
| irq_o | output | 1 | Interrupt request: pending AND enable |

## Verification
The assertions assume three things about the inputs. The divisor changes only through a control write, and such a write also restarts the prescaler. The count changes only by a tick or a bus load. Every write is a one-cycle strobe with stable address and data. The stimulus drives each bus operation for exactly one cycle, starting on a falling edge. It places interrupt-register writes on chosen cycles relative to a known wrap, both on a wrap cycle and away from one, so the set-versus-clear ordering is exercised on purpose. Expected counts come from the number of rising edges between the enabling write and each read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int CNT_W    = 28;
  localparam int DIV_W    = 16;
  localparam int BIT_RUN  = 28;
  localparam int BIT_PER  = 24;
  localparam int BIT_IEN  = 20;
  localparam int BIT_PEND = 16;

  typedef enum logic [1:0] {
    SEL_MARK  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_INT   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] last_phase;

  // divisor 0 and 1 both mean one step per clock
  assign last_phase = (div <= ONE) ? '0 : div - ONE;
  assign tick = run && !restart && (phase_q == last_phase);

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= '0;
    else if (!run || restart || tick) phase_q <= '0;
    else phase_q <= phase_q + ONE;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div > ONE && !restart) |=> !tick); // R3
  AST_RESTART_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && div > ONE) |=> !tick); // R10
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] mark,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] step;
  logic             at_top;
  logic             hit_mark;

  assign step     = count_q + CNT_W'(1);
  assign at_top   = &count_q;
  assign hit_mark = (mark != '0) && (step == mark);
  assign wrap     = tick && (at_top || hit_mark);
  assign count    = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else if (load) count_q <= load_val;
    else if (tick) count_q <= wrap ? '0 : step;
  end

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count_q)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap && !load) |=> (count_q == $past(count_q) + CNT_W'(1))); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !load) |=> (count_q == '0)); // R4
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count_q == $past(load_val))); // R10
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_ien,
  input  logic wr_clr,
  input  logic set,
  output logic ien,
  output logic pend,
  output logic irq
);
  logic ien_q;
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr) ien_q <= wr_ien;
      if (set) pend_q <= 1'b1;
      else if (wr && wr_clr) pend_q <= 1'b0;
    end
  end

  assign ien  = ien_q;
  assign pend = pend_q;
  assign irq  = pend_q & ien_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> pend_q); // R9
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wr_clr && !set) |=> !pend_q); // R9
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !(wr && wr_clr)) |=> pend_q); // R9
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int DW = DIV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - CW;

  reg_sel_e sel;
  logic     wr_mark, wr_count, wr_ctrl, wr_int;

  logic [CW-1:0] mark_q;
  logic          run_q;
  logic          per_q;
  logic [DW-1:0] div_q;

  logic          tick;
  logic          wrap;
  logic [CW-1:0] count;
  logic          ien, pend;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0]};

  assign sel      = reg_sel_e'(bus_addr[3:2]);
  assign wr_mark  = bus_we && (sel == SEL_MARK);
  assign wr_count = bus_we && (sel == SEL_COUNT);
  assign wr_ctrl  = bus_we && (sel == SEL_CTRL);
  assign wr_int   = bus_we && (sel == SEL_INT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mark_q <= '0;
      run_q  <= 1'b0;
      per_q  <= 1'b0;
      div_q  <= '0;
    end else begin
      if (wr_mark) mark_q <= bus_wdata[CW-1:0];
      if (wr_ctrl) begin
        run_q <= bus_wdata[BIT_RUN];
        per_q <= bus_wdata[BIT_PER];
        div_q <= bus_wdata[DW-1:0];
      end else if (wrap && !per_q) begin
        run_q <= 1'b0;
      end
    end
  end

  tmr_prescale #(.DIV_W(DW)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .restart (wr_ctrl || wr_count),
    .div     (div_q),
    .tick    (tick)
  );

  tmr_count #(.CNT_W(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (wr_count),
    .load_val (bus_wdata[CW-1:0]),
    .mark     (mark_q),
    .count    (count),
    .wrap     (wrap)
  );

  tmr_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr_int),
    .wr_ien (bus_wdata[BIT_IEN]),
    .wr_clr (bus_wdata[BIT_PEND]),
    .set    (wrap),
    .ien    (ien),
    .pend   (pend),
    .irq    (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_MARK:  bus_rdata = {{PAD_W{1'b0}}, mark_q};
      SEL_COUNT: bus_rdata = {{PAD_W{1'b0}}, count};
      SEL_CTRL: begin
        bus_rdata[BIT_RUN] = run_q;
        bus_rdata[BIT_PER] = per_q;
        bus_rdata[DW-1:0]  = div_q;
      end
      SEL_INT: begin
        bus_rdata[BIT_IEN]  = ien;
        bus_rdata[BIT_PEND] = pend;
      end
      default: bus_rdata = '0;
    endcase
  end

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !per_q && !wr_ctrl) |=> !run_q); // R7
  AST_PERIODIC_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && per_q && !wr_ctrl) |=> run_q); // R6
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_count) |=> $stable(count)); // R11
  AST_WRAP_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> pend); // R8
endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    bit          is_irq;
    string       tag;
  } item_t;
  item_t sb_q[$];

  localparam logic [3:0] A_MARK = 4'h0, A_CNT = 4'h4, A_CTL = 4'h8, A_INT = 4'hC;

  tick_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  // driver: each task occupies one cycle starting at a falling edge
  task automatic op_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
  endtask

  task automatic op_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    it.exp = e; it.is_irq = 1'b0; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic op_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    bus_we = 1'b0;
    it.exp = {31'd0, e}; it.is_irq = 1'b1; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic op_idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_we = 1'b0;
    end
  endtask

  // monitor: samples 3 ns after each falling edge, well away from rising edges
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = it.is_irq ? {31'd0, irq_o} : bus_rdata;
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    op_rd(A_MARK, 32'h0, "R1 mark");
    op_rd(A_CNT,  32'h0, "R1 count");
    op_rd(A_CTL,  32'h0, "R1 ctrl");
    op_rd(A_INT,  32'h0, "R1 int");
    op_irq(1'b0, "R1 irq");
    op_idle(3);
    op_rd(A_CNT,  32'h0, "R1 count frozen");

    // R2 unused bits read 0, pending cannot be set by a write
    op_wr(A_MARK, 32'hFFFF_FFFF);
    op_rd(A_MARK, 32'h0FFF_FFFF, "R2 mark width");
    op_wr(A_INT,  32'hFFFF_FFFF);
    op_rd(A_INT,  32'h0010_0000, "R2 int bits");
    op_wr(A_INT,  32'h0);
    op_wr(A_CTL,  32'hFFFF_FFFF);
    op_rd(A_CTL,  32'h1100_FFFF, "R2 ctrl bits");
    op_wr(A_CTL,  32'h0);
    op_wr(A_CNT,  32'h0);
    op_wr(A_MARK, 32'h0);

    // R3 divisor 1; R11 stop on control 0
    op_wr(A_CTL, 32'h1100_0001);
    op_rd(A_CNT, 32'd0, "R3 div1 j1");
    op_idle(2);
    op_rd(A_CNT, 32'd3, "R3 div1 j4");
    op_wr(A_CTL, 32'h0);
    op_rd(A_CNT, 32'd4, "R11 stop value");
    op_idle(3);
    op_rd(A_CNT, 32'd4, "R11 stays stopped");

    // R3 divisor 0 behaves as 1
    op_wr(A_CNT, 32'h0);
    op_wr(A_CTL, 32'h1100_0000);
    op_idle(2);
    op_rd(A_CNT, 32'd2, "R3 div0");
    op_wr(A_CTL, 32'h0);

    // R3 divisor 4; R10 load restarts phase
    op_wr(A_CNT, 32'h0);
    op_wr(A_CTL, 32'h1100_0004);
    op_idle(8);
    op_rd(A_CNT, 32'd2, "R3 div4 j9");
    op_rd(A_CNT, 32'd2, "R3 div4 j10");
    op_wr(A_CNT, 32'd100);
    op_rd(A_CNT, 32'd100, "R10 loaded");
    op_rd(A_CNT, 32'd100, "R10 phase restarted");
    op_idle(2);
    op_rd(A_CNT, 32'd101, "R10 first step after load");
    op_wr(A_CTL, 32'h0);

    // R4 R6 R8 R9 periodic with end marker 5
    op_wr(A_CNT,  32'h0);
    op_wr(A_MARK, 32'd5);
    op_wr(A_INT,  32'h0010_0000);
    op_wr(A_CTL,  32'h1100_0001);            // j=0
    op_rd(A_CNT, 32'd0, "R4 j1");           // j=1
    op_idle(2);                              // j=2,3
    op_rd(A_CNT, 32'd3, "R4 j4");           // j=4
    op_rd(A_CNT, 32'd4, "R4 below marker"); // j=5
    op_rd(A_CNT, 32'd0, "R4 wrapped");      // j=6
    op_rd(A_INT, 32'h0011_0000, "R8 pending on wrap"); // j=7
    op_irq(1'b1, "R8 irq high");            // j=8
    op_rd(A_CNT, 32'd3, "R6 keeps counting");          // j=9
    op_rd(A_CTL, 32'h1100_0001, "R6 run bit kept");    // j=10
    op_wr(A_INT, 32'h0011_0000);             // j=11 clear
    op_rd(A_INT, 32'h0010_0000, "R9 cleared");          // j=12
    op_irq(1'b0, "R8 irq low after clear");             // j=13
    op_idle(2);                              // j=14,15 (wrap at 15)
    op_wr(A_INT, 32'h0010_0000);             // j=16 write 0 to pending
    op_rd(A_INT, 32'h0011_0000, "R9 zero write ignored"); // j=17
    op_wr(A_INT, 32'h0011_0000);             // j=18 clear
    op_idle(1);                              // j=19
    op_wr(A_INT, 32'h0011_0000);             // j=20 clear on wrap cycle
    op_rd(A_INT, 32'h0011_0000, "R9 set wins over clear"); // j=21
    op_wr(A_CTL, 32'h0);
    op_wr(A_INT, 32'h0001_0000);

    // R7 one-shot with end marker 3
    op_wr(A_CNT,  32'h0);
    op_wr(A_MARK, 32'd3);
    op_wr(A_CTL,  32'h1000_0001);            // j=0
    op_idle(1);                              // j=1
    op_rd(A_CNT, 32'd1, "R7 counting");     // j=2
    op_idle(1);                              // j=3
    op_rd(A_CNT, 32'd0, "R7 wrapped");      // j=4
    op_rd(A_CTL, 32'h0000_0001, "R7 run bit cleared"); // j=5
    op_idle(2);
    op_rd(A_CNT, 32'd0, "R7 stopped");      // j=8
    op_rd(A_INT, 32'h0001_0000, "R8 pending one-shot"); // j=9
    op_irq(1'b0, "R8 irq gated by enable");             // j=10
    op_wr(A_INT, 32'h0001_0000);

    // R5 end marker 0, wrap only past all ones
    op_wr(A_MARK, 32'h0);
    op_wr(A_CNT,  32'h0FFF_FFFE);
    op_wr(A_CTL,  32'h1100_0001);            // j=0
    op_rd(A_CNT, 32'h0FFF_FFFE, "R5 j1");
    op_rd(A_CNT, 32'h0FFF_FFFF, "R5 top value");
    op_rd(A_CNT, 32'h0, "R5 overflow wrap");
    op_rd(A_INT, 32'h0001_0000, "R5 overflow pends");
    op_wr(A_CTL, 32'h0);

    op_idle(3);
    while (sb_q.size() > 0) @(negedge clk);
    op_idle(1);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule